// File: doc/BRIEF.md
# Protected Save-Area Lock Register

This block is a one-byte control register that arms protection of a fixed save-area memory range. Software first negotiates by writing a query code. The register answers with an acknowledge code, and from then on only a single lock bit can be written. Setting that bit locks the register for good. After that, the register holds a fixed value and only a reset releases it.

While locked, two flags drive the memory router elsewhere in the chip. One flag hides the range from ordinary accesses, so reads return all ones and writes are dropped. The other flag makes the range visible to management-mode accesses. A feature strap gates the whole mechanism. With the strap low, writes have no effect and both flags stay low.

The write port is a valid/ready stream that never applies back-pressure. `wr_ready` is always high, and a beat is taken on every rising clock edge where `wr_valid` is high. The read port is a plain output that always shows the current register value.

Top module: `smbase_lock_reg`

## Requirements
- R1: After reset, `rd_data` is 0x00, both flags are low, and the internal write mask is 0xFF.
- R2: While `feat_en` is low, accepted writes leave `rd_data` unchanged and both flags are low, even when the register is locked.
- R3: Before a query, any write other than 0xFF is discarded, and `rd_data` reads 0x00 on the next cycle. This includes a write of the lock bit 0x02.
- R4: Writing the query code 0xFF while the write mask is 0xFF makes `rd_data` read the acknowledge code 0x01 on the next cycle.
- R5: After the query, only bit 1 is writable. A write with bit 1 clear leaves `rd_data` at 0x01 and the flags low.
- R6: After the query, a write with bit 1 set makes `rd_data` read 0x02 on the next cycle, and both flags rise.
- R7: Once locked, every further write leaves `rd_data` at 0x02 until reset.
- R8: `range_hidden` and `range_smm_visible` are always equal. They are high exactly when the register is locked and `feat_en` is high.
- R9: Asserting reset from the locked state restores the state of R1. A lock-bit write straight after that reset is discarded.
- R10: `wr_ready` is high at all times outside reset.
- R11: A second write of 0xFF after the query sets bit 1, so it locks the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Feature strap; low disables writes and flags |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, always high |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Current register value |
| range_hidden | output | 1 | Range hidden from ordinary accesses |
| range_smm_visible | output | 1 | Range exposed to management accesses |

## Verification
The bench targets several corner cases, and each one exposes a specific design mistake:
- **Lock bit before a query.** A design that applied the mask too early would lock here, with no negotiation.
- **A cleared lock bit after the query.** A design that let other bits through would read back something other than 0x01.
- **A repeated query code after the query.** This must lock the register. A design that tested for the query code before applying the mask would stay armed.
- **Writes of 0x00 and 0xFF while locked.** A design that failed to freeze the value would drift, or re-arm the query path.
- **Dropping the strap while locked.** A design that latched the flags would keep protecting the range.
- **Reset from lock.** A design that kept any stale state would accept the lock bit immediately after reset.

// File: rtl/smlk_pkg.sv
package smlk_pkg;
  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } smlk_state_e;
endpackage

// File: rtl/smlk_decode.sv
module smlk_decode
  import smlk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ACK_CODE = 8'h01,
  parameter int LOCK_IDX = 1
) (
  input  smlk_state_e        state,
  output logic [DATA_W-1:0]  cur_val,
  output logic [DATA_W-1:0]  cur_mask
);
  localparam logic [DATA_W-1:0] LOCK_BIT = DATA_W'(1) << LOCK_IDX;

  // Value and write mask are both pure functions of the state.
  always_comb begin
    unique case (state)
      ST_ARMED: begin
        cur_val  = ACK_CODE;
        cur_mask = LOCK_BIT;
      end
      ST_LOCKED: begin
        cur_val  = LOCK_BIT;
        cur_mask = '0;
      end
      default: begin
        cur_val  = '0;
        cur_mask = '1;
      end
    endcase
  end
endmodule

// File: rtl/smlk_merge.sv
module smlk_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] cur_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] merged
);
  // A bit takes the written value where the mask is set,
  // and keeps its current value elsewhere.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = cur_mask[i] ? wr_data[i] : cur_val[i];
  end
endmodule

// File: rtl/smlk_ctrl.sv
module smlk_ctrl
  import smlk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] QUERY_CODE = 8'hFF,
  parameter int LOCK_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] merged,
  input  logic [DATA_W-1:0] cur_mask,
  output smlk_state_e       state
);
  smlk_state_e state_nx;

  // Rule order: the query match, then the discard while the mask is
  // still open, then the lock bit.
  always_comb begin
    state_nx = state;
    if (wr_fire) begin
      if (merged == QUERY_CODE)
        state_nx = ST_ARMED;
      else if (&cur_mask)
        state_nx = ST_OPEN;
      else if (merged[LOCK_IDX])
        state_nx = ST_LOCKED;
      else
        state_nx = state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OPEN;
    else        state <= state_nx;
  end
endmodule

// File: rtl/smbase_lock_reg.sv
module smbase_lock_reg
  import smlk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] QUERY_CODE = 8'hFF,
  parameter logic [DATA_W-1:0] ACK_CODE   = 8'h01,
  parameter int LOCK_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              range_hidden,
  output logic              range_smm_visible
);
  smlk_state_e       state;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] cur_mask;
  logic [DATA_W-1:0] merged;
  logic              wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready & feat_en;

  smlk_decode #(.DATA_W(DATA_W), .ACK_CODE(ACK_CODE), .LOCK_IDX(LOCK_IDX)) u_dec (
    .state    (state),
    .cur_val  (cur_val),
    .cur_mask (cur_mask)
  );

  smlk_merge #(.DATA_W(DATA_W)) u_mrg (
    .cur_val  (cur_val),
    .cur_mask (cur_mask),
    .wr_data  (wr_data),
    .merged   (merged)
  );

  smlk_ctrl #(.DATA_W(DATA_W), .QUERY_CODE(QUERY_CODE), .LOCK_IDX(LOCK_IDX)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .merged   (merged),
    .cur_mask (cur_mask),
    .state    (state)
  );

  assign rd_data           = cur_val;
  assign range_hidden      = feat_en & (state == ST_LOCKED);
  assign range_smm_visible = feat_en & (state == ST_LOCKED);
endmodule

// File: rtl/smlk_chk.sv
module smlk_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] QUERY_CODE = 8'hFF,
  parameter logic [DATA_W-1:0] ACK_CODE   = 8'h01,
  parameter int LOCK_IDX = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              feat_en,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              range_hidden,
  input logic              range_smm_visible
);
  localparam logic [DATA_W-1:0] LOCK_VAL = DATA_W'(1) << LOCK_IDX;

  p_flags_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    range_hidden == range_smm_visible);

  p_strap_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |-> (!range_hidden && !range_smm_visible));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == LOCK_VAL) |=> (rd_data == LOCK_VAL));

  p_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0 && wr_valid && feat_en && wr_data != QUERY_CODE) |=> (rd_data == '0));

  p_query_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0 && wr_valid && feat_en && wr_data == QUERY_CODE) |=> (rd_data == ACK_CODE));

  p_always_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind smbase_lock_reg smlk_chk #(
  .DATA_W(DATA_W), .QUERY_CODE(QUERY_CODE), .ACK_CODE(ACK_CODE), .LOCK_IDX(LOCK_IDX)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .feat_en           (feat_en),
  .wr_valid          (wr_valid),
  .wr_ready          (wr_ready),
  .wr_data           (wr_data),
  .rd_data           (rd_data),
  .range_hidden      (range_hidden),
  .range_smm_visible (range_smm_visible)
);

// File: tb/sim_smbase_lock_reg.sv
module sim_smbase_lock_reg;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       feat_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic [7:0] rd_data;
  logic       range_hidden;
  logic       range_smm_visible;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [7:0] rd;
    logic       fl;
    int         at;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smbase_lock_reg u0 (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_data(rd_data), .range_hidden(range_hidden),
    .range_smm_visible(range_smm_visible)
  );

  task automatic compare(input string tag, input logic [7:0] rd, input logic fl);
    checks++;
    if (rd_data !== rd || range_hidden !== fl || range_smm_visible !== fl) begin
      errors++;
      $display("FAIL %s: rd=%02h hid=%b vis=%b expected rd=%02h flags=%b",
               tag, rd_data, range_hidden, range_smm_visible, rd, fl);
    end
  endtask

  // Monitor: pops expected items once the edge that applies them has passed.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].at < cyc) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.tag, e.rd, e.fl);
    end
  end

  task automatic push(input logic [7:0] rd, input logic fl, input string tag);
    exp_t e;
    e.rd = rd; e.fl = fl; e.at = cyc; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] rd, input logic fl, input string tag);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = d;
    push(rd, fl, tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 20000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset value", 8'h00, 1'b0);
    checks++;
    if (wr_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10: wr_ready=%b expected 1", wr_ready);
    end

    // R2: strap off, writes have no effect
    wr(8'hFF, 8'h00, 1'b0, "R2 query with strap low");
    wr(8'h02, 8'h00, 1'b0, "R2 lock with strap low");
    idle(); drain();
    feat_en = 1'b1;

    // R3: discard before the query
    wr(8'h5A, 8'h00, 1'b0, "R3 random byte");
    wr(8'h02, 8'h00, 1'b0, "R3 lock bit before query");
    // R4 and R1 (open mask): query acknowledges
    wr(8'hFF, 8'h01, 1'b0, "R4 query ack");
    wr(8'hFD, 8'h01, 1'b0, "R5 bit1 clear stays armed, R8 flags low");
    wr(8'h02, 8'h02, 1'b1, "R6 lock, R8 flags high");
    wr(8'h00, 8'h02, 1'b1, "R7 write 00 while locked");
    wr(8'hFF, 8'h02, 1'b1, "R7 write FF while locked");
    wr(8'h01, 8'h02, 1'b1, "R7 write 01 while locked");
    idle(); drain();

    // R2: strap dropped while locked
    @(posedge clk); #1 feat_en = 1'b0;
    push(8'h02, 1'b0, "R2 strap low while locked");
    drain();
    @(posedge clk); #1 feat_en = 1'b1;
    push(8'h02, 1'b1, "R8 strap back high, still locked");
    drain();

    // R9: reset from lock
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    push(8'h00, 1'b0, "R9 reset from lock");
    drain();
    wr(8'h02, 8'h00, 1'b0, "R9 lock bit after reset discarded");
    wr(8'hFF, 8'h01, 1'b0, "R9 query after reset");
    wr(8'hFF, 8'h02, 1'b1, "R11 second query code locks");
    idle(); drain();

    summary();
  end
endmodule